// File: doc/BRIEF.md
# Address-Routing Bus Decoder with Side-Effect-Free Access Probe

This block sits between two bus masters and four slave peripherals on a pipelined, Wishbone-style bus. It chooses one master at a time by round-robin. It matches that master's address against four parameterised regions, each described by a base, a mask and separate read and write permission bits. It then forwards the strobe and cycle only to the slave that owns the address. An access that no region accepts never reaches a slave. Such an access is either unmapped, or it is a write to a region that forbids writes, or a read from a region that forbids reads. The block answers it with an error response.

Requests may be pipelined. Up to four requests can be outstanding at once, and a small order queue records the destination of each one, either a slave or an error. Acknowledges and errors therefore return to the master in issue order.

A separate probe port lets speculative logic ask whether an access to a given address and direction would be accepted. The probe uses the same region and permission rules as the live decode. It answers in the same cycle, and it never strobes a slave or alters any state, even while a transfer is in flight.

Top module: `bus_route_decoder`

## Requirements
- R1: While reset is held, and until some master raises its cycle, every master sees stall high, every slave sees cycle and strobe low, and no acknowledge or error is given.
- R2: A master whose cycle is high is granted the bus one clock later, when no master owns the bus. If both masters request, the one not granted last wins. The owner keeps the bus until its cycle is low and no response is outstanding. A non-owner always sees stall high.
- R3: Region k matches when (address AND mask_k) equals base_k. The lowest-numbered matching region wins. An accepted-path strobe goes to that slave only, in the same cycle, carrying the owner's address, write flag and write data.
- R4: A slave's cycle is high only while the owner's cycle is high and that slave is either strobed this cycle or still owes a response.
- R5: A request that matches no region strobes no slave and is answered with an error pulse to its master.
- R6: A write to a region whose write bit is 0, or a read from a region whose read bit is 0, is refused exactly like an unmapped address: no slave strobe, and an error response.
- R7: The probe output is high in the same cycle exactly when the probed address and direction would be accepted under R3 and R6. Probe inputs have no effect on any bus output.
- R8: Requests may be accepted on consecutive cycles. Responses reach the master in issue order. An error is given in the cycle after its request becomes the oldest outstanding one, and never more than one response pulse occurs per cycle.
- R9: At most four requests are outstanding. With four outstanding, the owner is stalled and no slave is strobed.
- R10: The owner is stalled when the target slave asserts its stall. It is also stalled, with no strobe, when the target slave differs from a slave that still owes a response.
- R11: When the slave owing the oldest response acknowledges, the owner sees the acknowledge in that same cycle, with that slave's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc_i | input | NM | Per-master cycle request |
| m_stb_i | input | NM | Per-master strobe |
| m_we_i | input | NM | Per-master write flag |
| m_adr_i | input | NM x AW | Per-master address |
| m_dat_i | input | NM x DW | Per-master write data |
| m_stall_o | output | NM | Per-master stall |
| m_ack_o | output | NM | Per-master acknowledge |
| m_err_o | output | NM | Per-master error response |
| m_dat_o | output | DW | Read data to the masters |
| s_cyc_o | output | NS | Per-slave cycle |
| s_stb_o | output | NS | Per-slave strobe |
| s_we_o | output | 1 | Write flag to the slaves |
| s_adr_o | output | AW | Address to the slaves |
| s_dat_o | output | DW | Write data to the slaves |
| s_stall_i | input | NS | Per-slave stall |
| s_ack_i | input | NS | Per-slave acknowledge |
| s_dat_i | input | NS x DW | Per-slave read data |
| chk_adr_i | input | AW | Probe address |
| chk_we_i | input | 1 | Probe direction, 1 for write |
| chk_ok_o | output | 1 | Probe result, 1 when the access would be accepted |

## Verification
Only the grant is registered. It is due one clock after the cycle request. Stall, slave strobe, slave cycle, the probe result and forwarded acknowledges with their data all follow their inputs in the same cycle. An error is due one clock after its request is accepted, or later if older responses are still pending. The bench applies stimulus on the falling edge and compares every output 2 ns later against a behavioural model that keeps queues of outstanding destinations and pending slave replies. The model state advances once per cycle at that same point, so each expected value lines up with the cycle in which the design produces it.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
    localparam int unsigned DEF_NM    = 2;
    localparam int unsigned DEF_NS    = 4;
    localparam int unsigned DEF_AW    = 16;
    localparam int unsigned DEF_DW    = 32;
    localparam int unsigned DEF_DEPTH = 4;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_ERR  = 2'd2
    } rsp_e;
endpackage

// File: rtl/bdec_region_match.sv
module bdec_region_match #(
    parameter int unsigned NS = 4,
    parameter int unsigned AW = 16,
    parameter logic [NS-1:0][AW-1:0] BASE = '0,
    parameter logic [NS-1:0][AW-1:0] MASK = '0,
    parameter logic [NS-1:0] RD = '0,
    parameter logic [NS-1:0] WR = '0,
    localparam int unsigned DSTW = $clog2(NS + 1)
) (
    input  logic [AW-1:0]   adr,
    input  logic            we,
    output logic [DSTW-1:0] dest
);
    logic [NS-1:0] hit;

    for (genvar g = 0; g < NS; g++) begin : g_cmp
        assign hit[g] = ((adr & MASK[g]) == BASE[g]);
    end

    // scan from the top so that the lowest matching region is written last
    always_comb begin
        dest = DSTW'(NS);
        for (int k = NS - 1; k >= 0; k--) begin
            if (hit[k]) begin
                dest = (we ? WR[k] : RD[k]) ? DSTW'(k) : DSTW'(NS);
            end
        end
    end
endmodule

// File: rtl/bdec_rr_arbiter.sv
module bdec_rr_arbiter #(
    parameter int unsigned NM = 2,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic          rel_i,
    output logic          owner_vld,
    output logic [IW-1:0] owner_idx
);
    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        logic found;
        int   c;
        arb_d = arb_q;
        found = 1'b0;
        c     = 0;
        if (arb_q.vld) begin
            if (rel_i) arb_d.vld = 1'b0;
        end else begin
            for (int i = 1; i <= NM; i++) begin
                c = (int'(arb_q.last) + i) % NM;
                if (!found && req[c]) begin
                    found     = 1'b1;
                    arb_d.vld = 1'b1;
                    arb_d.idx = IW'(c);
                    arb_d.last = IW'(c);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '{vld: 1'b0, idx: '0, last: IW'(NM - 1)};
        end else begin
            arb_q <= arb_d;
        end
    end

    assign owner_vld = arb_q.vld;
    assign owner_idx = arb_q.idx;

    // R2
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_q.vld && (req != '0)) |=> (owner_vld && req[$past(arb_d.idx)]) || !$past(req[arb_d.idx]) || owner_vld);
endmodule

// File: rtl/bdec_order_fifo.sv
module bdec_order_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned NS = 4,
    parameter int unsigned W = 3,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_dest,
    input  logic          pop,
    output logic [W-1:0]  head_dest,
    output logic          empty,
    output logic          full,
    output logic [NS-1:0] pending
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } ofq_t;

    ofq_t ofq_d, ofq_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ofq_d = ofq_q;
        if (push) begin
            ofq_d.mem[ofq_q.wr] = push_dest;
            ofq_d.wr = step(ofq_q.wr);
        end
        if (pop) ofq_d.rd = step(ofq_q.rd);
        ofq_d.cnt = ofq_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ofq_q <= '0;
        else        ofq_q <= ofq_d;
    end

    always_comb begin
        int off;
        pending = '0;
        for (int j = 0; j < DEPTH; j++) begin
            off = (j - int'(ofq_q.rd) + DEPTH) % DEPTH;
            for (int k = 0; k < NS; k++) begin
                if (off < int'(ofq_q.cnt) && ofq_q.mem[j] == W'(k)) pending[k] = 1'b1;
            end
        end
    end

    assign head_dest = ofq_q.mem[ofq_q.rd];
    assign empty     = (ofq_q.cnt == '0);
    assign full      = (ofq_q.cnt == CW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/bus_route_decoder.sv
module bus_route_decoder
    import bdec_pkg::*;
#(
    parameter int unsigned NM    = DEF_NM,
    parameter int unsigned NS    = DEF_NS,
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter logic [NS-1:0][AW-1:0] REG_BASE = {16'h2000, 16'h2000, 16'h1000, 16'h0000},
    parameter logic [NS-1:0][AW-1:0] REG_MASK = {16'hF000, 16'hFF00, 16'hF000, 16'hF000},
    parameter logic [NS-1:0] REG_RD = 4'b0111,
    parameter logic [NS-1:0] REG_WR = 4'b1101
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          m_cyc_i,
    input  logic [NM-1:0]          m_stb_i,
    input  logic [NM-1:0]          m_we_i,
    input  logic [NM-1:0][AW-1:0]  m_adr_i,
    input  logic [NM-1:0][DW-1:0]  m_dat_i,
    output logic [NM-1:0]          m_stall_o,
    output logic [NM-1:0]          m_ack_o,
    output logic [NM-1:0]          m_err_o,
    output logic [DW-1:0]          m_dat_o,
    output logic [NS-1:0]          s_cyc_o,
    output logic [NS-1:0]          s_stb_o,
    output logic                   s_we_o,
    output logic [AW-1:0]          s_adr_o,
    output logic [DW-1:0]          s_dat_o,
    input  logic [NS-1:0]          s_stall_i,
    input  logic [NS-1:0]          s_ack_i,
    input  logic [NS-1:0][DW-1:0]  s_dat_i,
    input  logic [AW-1:0]          chk_adr_i,
    input  logic                   chk_we_i,
    output logic                   chk_ok_o
);
    localparam int unsigned DSTW = $clog2(NS + 1);
    localparam int unsigned IW   = (NM > 1) ? $clog2(NM) : 1;
    localparam logic [DSTW-1:0] ERR_DEST = DSTW'(NS);

    logic            owner_vld;
    logic [IW-1:0]   owner_idx;
    logic            cur_cyc, cur_stb, cur_we;
    logic [AW-1:0]   cur_adr;
    logic [DW-1:0]   cur_dat;
    logic [DSTW-1:0] bus_dest, chk_dest, head_dest;
    logic            bus_ok;
    logic            q_empty, q_full, q_pop, accept, go;
    logic [NS-1:0]   pending;
    logic            conflict, tgt_stall, rel;
    rsp_e            rsp;
    logic [DW-1:0]   rdata;

    // owner selection
    bdec_rr_arbiter #(.NM(NM)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (m_cyc_i),
        .rel_i     (rel),
        .owner_vld (owner_vld),
        .owner_idx (owner_idx)
    );

    always_comb begin
        cur_cyc = 1'b0;
        cur_stb = 1'b0;
        cur_we  = 1'b0;
        cur_adr = '0;
        cur_dat = '0;
        for (int i = 0; i < NM; i++) begin
            if (owner_vld && owner_idx == IW'(i)) begin
                cur_cyc = m_cyc_i[i];
                cur_stb = m_stb_i[i];
                cur_we  = m_we_i[i];
                cur_adr = m_adr_i[i];
                cur_dat = m_dat_i[i];
            end
        end
    end

    assign rel = owner_vld && !cur_cyc && q_empty;

    // live decode and the probe share one set of region rules
    bdec_region_match #(
        .NS(NS), .AW(AW), .BASE(REG_BASE), .MASK(REG_MASK), .RD(REG_RD), .WR(REG_WR)
    ) u_bus_map (
        .adr  (cur_adr),
        .we   (cur_we),
        .dest (bus_dest)
    );

    bdec_region_match #(
        .NS(NS), .AW(AW), .BASE(REG_BASE), .MASK(REG_MASK), .RD(REG_RD), .WR(REG_WR)
    ) u_chk_map (
        .adr  (chk_adr_i),
        .we   (chk_we_i),
        .dest (chk_dest)
    );

    assign bus_ok   = (bus_dest != ERR_DEST);
    assign chk_ok_o = (chk_dest != ERR_DEST);

    // hazards on the issue path
    always_comb begin
        conflict  = 1'b0;
        tgt_stall = 1'b0;
        for (int k = 0; k < NS; k++) begin
            if (bus_ok && pending[k] && bus_dest != DSTW'(k)) conflict = 1'b1;
            if (bus_dest == DSTW'(k)) tgt_stall = s_stall_i[k];
        end
    end

    assign go     = cur_cyc && cur_stb && !q_full && !conflict;
    assign accept = go && !tgt_stall;

    always_comb begin
        for (int k = 0; k < NS; k++) begin
            s_stb_o[k] = go && (bus_dest == DSTW'(k));
            s_cyc_o[k] = cur_cyc && (s_stb_o[k] || pending[k]);
        end
        for (int i = 0; i < NM; i++) begin
            m_stall_o[i] = !(owner_vld && owner_idx == IW'(i)) || q_full || conflict || tgt_stall;
        end
    end

    assign s_we_o  = cur_we;
    assign s_adr_o = cur_adr;
    assign s_dat_o = cur_dat;

    // in-order response steering
    bdec_order_fifo #(.DEPTH(DEPTH), .NS(NS), .W(DSTW)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_dest (bus_dest),
        .pop       (q_pop),
        .head_dest (head_dest),
        .empty     (q_empty),
        .full      (q_full),
        .pending   (pending)
    );

    always_comb begin
        rsp   = RSP_NONE;
        rdata = '0;
        if (!q_empty) begin
            if (head_dest == ERR_DEST) begin
                rsp = RSP_ERR;
            end else begin
                for (int k = 0; k < NS; k++) begin
                    if (head_dest == DSTW'(k) && s_ack_i[k]) begin
                        rsp   = RSP_ACK;
                        rdata = s_dat_i[k];
                    end
                end
            end
        end
    end

    assign q_pop = (rsp != RSP_NONE);

    always_comb begin
        for (int i = 0; i < NM; i++) begin
            m_ack_o[i] = owner_vld && owner_idx == IW'(i) && rsp == RSP_ACK;
            m_err_o[i] = owner_vld && owner_idx == IW'(i) && rsp == RSP_ERR;
        end
    end

    assign m_dat_o = rdata;

    // R3
    one_slave_stb_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_stb_o));
    // R4
    one_slave_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_cyc_o));
    // R8
    single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({m_ack_o, m_err_o}) <= 1);
    // R6
    refused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cyc && cur_stb && !bus_ok) |-> (s_stb_o == '0));
    // R2
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld && cur_cyc) |=> (owner_vld && $stable(owner_idx)));
    // R5
    err_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_err_o != '0) |-> owner_vld);
endmodule

// File: tb/bus_route_decoder_tb_top.sv
module bus_route_decoder_tb_top;
    localparam logic [3:0][15:0] BASE = {16'h2000, 16'h2000, 16'h1000, 16'h0000};
    localparam logic [3:0][15:0] MASK = {16'hF000, 16'hFF00, 16'hF000, 16'hF000};
    localparam logic [3:0] RDP = 4'b0111;
    localparam logic [3:0] WRP = 4'b1101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] m_cyc = '0, m_stb = '0, m_we = '0;
    logic [1:0][15:0] m_adr = '0;
    logic [1:0][31:0] m_dat = '0;
    logic [1:0] m_stall, m_ack, m_err;
    logic [31:0] m_rdat;
    logic [3:0] s_cyc, s_stb;
    logic s_we;
    logic [15:0] s_adr;
    logic [31:0] s_wdat;
    logic [3:0] s_stall = '0, s_ack = '0;
    logic [3:0][31:0] s_rdat = '0;
    logic [15:0] chk_adr = '0;
    logic chk_we = 1'b0;
    logic chk_ok;

    int checks = 0, errors = 0, cyc_n = 0;
    int q[$];
    int sq_dst[$];
    logic [31:0] sq_dat[$];
    logic [3:0] hold = '0;
    bit own_v = 0;
    int own = 0, last = 1, nd = 4, d = 0;
    logic full_e, conf_e, tst_e, cyc_e, stb_e, ack_e, err_e;
    logic [3:0] es_stb, es_cyc;
    logic [31:0] ack_dat = '0;

    always #5 clk = ~clk;

    bus_route_decoder #(
        .REG_BASE(BASE), .REG_MASK(MASK), .REG_RD(RDP), .REG_WR(WRP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr), .m_dat_i(m_dat),
        .m_stall_o(m_stall), .m_ack_o(m_ack), .m_err_o(m_err), .m_dat_o(m_rdat),
        .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we), .s_adr_o(s_adr), .s_dat_o(s_wdat),
        .s_stall_i(s_stall), .s_ack_i(s_ack), .s_dat_i(s_rdat),
        .chk_adr_i(chk_adr), .chk_we_i(chk_we), .chk_ok_o(chk_ok)
    );

    function automatic int ref_dest(input logic [15:0] a, input logic we);
        for (int k = 0; k < 4; k++) begin
            if ((a & MASK[k]) == BASE[k]) return (we ? WRP[k] : RDP[k]) ? k : 4;
        end
        return 4;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc_n);
        end
    endtask

    // slave models, behavioural reference and per-cycle comparison
    always begin
        @(negedge clk);
        cyc_n++;
        s_ack = '0;
        if (rst_n && sq_dst.size() != 0 && !hold[sq_dst[0]]) begin
            d = sq_dst[0];
            s_ack[d] = 1'b1;
            s_rdat[d] = sq_dat[0];
            ack_dat = sq_dat[0];
            void'(sq_dst.pop_front());
            void'(sq_dat.pop_front());
        end
        chk_adr = 16'(cyc_n * 16'h0731);
        chk_we = cyc_n[1];
        #2;
        chk("R7 probe", {31'd0, chk_ok}, {31'd0, ref_dest(chk_adr, chk_we) != 4});
        if (!rst_n) begin
            own_v = 0; last = 1; q.delete(); sq_dst.delete(); sq_dat.delete();
            chk("R1 reset stall", {30'd0, m_stall}, 32'd3);
            chk("R1 reset slave cyc/stb", {24'd0, s_cyc, s_stb}, 32'd0);
            chk("R1 reset responses", {28'd0, m_ack, m_err}, 32'd0);
        end else begin
            cyc_e = own_v && m_cyc[own];
            stb_e = cyc_e && m_stb[own];
            nd = own_v ? ref_dest(m_adr[own], m_we[own]) : 4;
            full_e = (q.size() == 4);
            conf_e = 1'b0;
            if (nd < 4) foreach (q[j]) if (q[j] != 4 && q[j] != nd) conf_e = 1'b1;
            tst_e = (nd < 4) && s_stall[nd];
            es_stb = '0; es_cyc = '0;
            for (int k = 0; k < 4; k++) begin
                es_stb[k] = stb_e && !full_e && !conf_e && nd == k;
                es_cyc[k] = cyc_e && (es_stb[k] || (q.size() != 0 && (k inside {q})));
            end
            ack_e = (q.size() != 0) && q[0] != 4 && s_ack[q[0]];
            err_e = (q.size() != 0) && q[0] == 4;
            for (int i = 0; i < 2; i++) begin
                if (!(own_v && own == i)) begin
                    chk("R2 non-owner stall", {31'd0, m_stall[i]}, 32'd1);
                    chk("R8 non-owner quiet", {30'd0, m_ack[i], m_err[i]}, 32'd0);
                end else begin
                    if (m_stb[i]) chk("R9 R10 owner stall", {31'd0, m_stall[i]},
                                      {31'd0, full_e || conf_e || tst_e});
                    chk("R11 ack", {31'd0, m_ack[i]}, {31'd0, ack_e});
                    chk("R5 R6 R8 err", {31'd0, m_err[i]}, {31'd0, err_e});
                end
            end
            chk("R3 R5 R6 slave stb", {28'd0, s_stb}, {28'd0, es_stb});
            chk("R4 slave cyc", {28'd0, s_cyc}, {28'd0, es_cyc});
            if (es_stb != '0) chk("R3 fields", {s_adr, 15'd0, s_we} ^ s_wdat,
                                  {m_adr[own], 15'd0, m_we[own]} ^ m_dat[own]);
            if (ack_e) chk("R11 read data", m_rdat, ack_dat);
            // advance the reference state by one clock
            if (ack_e || err_e) void'(q.pop_front());
            if (stb_e && !(full_e || conf_e || tst_e)) begin
                q.push_back(nd);
                if (nd < 4) begin
                    sq_dst.push_back(nd);
                    sq_dat.push_back({16'(nd) + 16'hA500, m_adr[own]});
                end
            end
            if (own_v) begin
                if (!m_cyc[own] && q.size() == 0) own_v = 0;
            end else begin
                for (int i = 1; i <= 2; i++) begin
                    if (!own_v && m_cyc[(last + i) % 2]) begin
                        own = (last + i) % 2; last = own; own_v = 1;
                    end
                end
            end
        end
    end

    task automatic issue(input int m, input logic [15:0] a, input logic we, input logic [31:0] dv);
        logic st;
        m_adr[m] = a; m_we[m] = we; m_dat[m] = dv; m_stb[m] = 1'b1;
        forever begin
            #1 st = m_stall[m];
            @(negedge clk);
            if (!st) break;
        end
        m_stb[m] = 1'b0;
    endtask

    task automatic drain(input int m);
        while (q.size() != 0) @(negedge clk);
        m_cyc[m] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle after reset, R2 grant, R3 plain read and write
        m_cyc[0] = 1'b1;
        issue(0, 16'h0010, 1'b0, 32'h0);
        issue(0, 16'h0020, 1'b1, 32'h1111_2222);
        drain(0);
        // R3 priority, R5 unmapped, R6 permission refusals
        m_cyc[0] = 1'b1;
        issue(0, 16'h2050, 1'b0, 32'h0);
        issue(0, 16'h2150, 1'b1, 32'h3333_0000);
        issue(0, 16'h2150, 1'b0, 32'h0);
        issue(0, 16'h1004, 1'b1, 32'h4444_0000);
        issue(0, 16'h1004, 1'b0, 32'h0);
        issue(0, 16'h5000, 1'b0, 32'h0);
        drain(0);
        // R8 back-to-back writes
        m_cyc[0] = 1'b1;
        for (int i = 0; i < 4; i++) issue(0, 16'h2000 + 16'(i), 1'b1, 32'(i) + 32'h77);
        drain(0);
        // R9 fill to four outstanding, then a fifth request waits
        m_cyc[0] = 1'b1;
        hold[0] = 1'b1;
        for (int i = 0; i < 4; i++) issue(0, 16'h0100 + 16'(i), 1'b0, 32'h0);
        m_adr[0] = 16'h0104; m_we[0] = 1'b0; m_stb[0] = 1'b1;
        repeat (3) @(negedge clk);
        hold[0] = 1'b0;
        issue(0, 16'h0104, 1'b0, 32'h0);
        drain(0);
        // R10 target slave stall
        m_cyc[0] = 1'b1;
        s_stall[1] = 1'b1;
        m_adr[0] = 16'h1008; m_we[0] = 1'b0; m_stb[0] = 1'b1;
        repeat (3) @(negedge clk);
        s_stall[1] = 1'b0;
        issue(0, 16'h1008, 1'b0, 32'h0);
        // R10 different slave while another owes a reply; R8 error queued behind
        hold[0] = 1'b1;
        issue(0, 16'h0200, 1'b0, 32'h0);
        issue(0, 16'h7000, 1'b1, 32'h0);
        m_adr[0] = 16'h1200; m_we[0] = 1'b0; m_stb[0] = 1'b1;
        repeat (3) @(negedge clk);
        hold[0] = 1'b0;
        issue(0, 16'h1200, 1'b0, 32'h0);
        drain(0);
        // R2 both masters request: the one not granted last wins
        m_cyc = 2'b11;
        issue(1, 16'h0300, 1'b1, 32'hABCD_0001);
        drain(1);
        issue(0, 16'h2004, 1'b0, 32'h0);
        drain(0);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: ran %0d cycles, expected fewer than %0d", cyc_n, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule